// File: doc/BRIEF.md
# Parallel Host Data Port

This block links a 16-bit asynchronous host bus to a 64-bit internal data path. The host reaches a small register window through a select pin, a 4-bit address, data strobes and a 16-bit data bus. Four 16-bit data slots form one 64-bit word. A host write to the closing slot address sends the assembled word into a host-to-core FIFO. A host read of that address takes the oldest word out of a core-to-host FIFO. The core side moves whole words with a valid/ready handshake.

All host pins pass through a synchronizer in the core clock domain. An access takes effect when the synchronized strobe ends. Request outputs pace the host. They come either as one shared line or as a separate read line and write line, and their polarity can be set. A build parameter selects the strobe style (separate read and write strobes, or one strobe qualified by a read/write line) and the polarity of the select and strobe pins. A control register selects byte-lane order, request style and request polarity at run time.

Top module: `hdp_port`

## Requirements
- R1: After reset, h2c_valid_o is low, c2h_ready_o is high and the control register reads 0 (little-endian, single request, active-low requests).
- R2: With DUAL_STROBE=1, hstb_a_i is the read strobe and hstb_b_i is the write strobe. With DUAL_STROBE=0, hstb_a_i is the only strobe and hrw_i selects the direction (1 = read, 0 = write). STB_ACT_HIGH sets the active level of hsel_i and both strobes. Any build, driven with equivalent pin activity, gives the same port results.
- R3: Addresses 4 to 7 are data slots. Slot k occupies word bits [16k+15:16k]. When control bit 0 is 0, address a reaches slot 7−a. When a write to address 7 ends, the assembled word (the slots written earlier plus this one) enters the host-to-core FIFO.
- R4: When control bit 0 is 1, address a reaches slot a−4. Address 7 still closes the word.
- R5: A host read of address 4 to 7 returns the matching slot of the oldest core-to-host word. Only a read of address 7 removes that word.
- R6: A read of address 7 while the core-to-host FIFO is empty removes nothing. The status register still shows no word waiting, and the next word the core supplies reads back whole.
- R7: A write to address 7 while the host-to-core FIFO already holds FIFO_DEPTH words is discarded.
- R8: Address 0 is read-only status: bit 0 is high when a core-to-host word is waiting, bit 1 is high when the host-to-core FIFO has room. Address 1 is the control register, read/write on bits [2:0]: bit 0 selects big-endian, bit 1 selects dual request, bit 2 selects active-high requests. Every other non-slot address reads 0, and writes to it change nothing.
- R9: In single-request mode, hreq_o is active while a core-to-host word waits or the host-to-core FIFO has room. hreq_rd_o and hreq_wr_o stay inactive.
- R10: In dual-request mode, hreq_rd_o is active while the core-to-host FIFO is not empty and hreq_wr_o is active while the host-to-core FIFO is not full. hreq_o stays inactive.
- R11: With control bit 2 at 0, an active request pin is low. With control bit 2 at 1, it is high.
- R12: With SYNC_STAGES=2, a request pin reflects a closing-slot access no more than 5 core clock cycles after the strobe ends at the pin.
- R13: h2c_valid_o is high while the host-to-core FIFO holds a word. While h2c_valid_o is high and h2c_ready_i is low, h2c_data_o does not change. c2h_ready_o is low while the core-to-host FIFO is full, and a word offered then is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hsel_i | input | 1 | Host chip select, level set by STB_ACT_HIGH |
| hstb_a_i | input | 1 | Read strobe (dual style) or data strobe (single style) |
| hstb_b_i | input | 1 | Write strobe (dual style), unused in single style |
| hrw_i | input | 1 | Direction in single style, 1 = read |
| haddr_i | input | 4 | Register address |
| hdata_i | input | DW | Host write data |
| hdata_o | output | DW | Host read data |
| hdata_oe_o | output | 1 | High while a selected read is in progress |
| hreq_o | output | 1 | Shared request (single-request mode) |
| hreq_rd_o | output | 1 | Read request (dual-request mode) |
| hreq_wr_o | output | 1 | Write request (dual-request mode) |
| h2c_valid_o | output | 1 | Host-to-core word available |
| h2c_data_o | output | 4*DW | Host-to-core word |
| h2c_ready_i | input | 1 | Core takes the host-to-core word |
| c2h_valid_i | input | 1 | Core offers a word |
| c2h_data_i | input | 4*DW | Core-to-host word |
| c2h_ready_o | output | 1 | Core-to-host FIFO has room |

## Verification
A slot index that slips or ignores the endianness bit shows up as swapped or repeated 16-bit lanes. This appears in the next word the core takes, or in the next host read, within one word transfer. A FIFO count that drifts shows on the status bits and on the request pins within a cycle of the drift. It also shows as a missing, duplicated or extra word at the end of a burst. An edge detector that fires twice or not at all appears as a doubled pop or a word that never leaves, both visible on the first closing-slot access. The single-strobe, active-high build is driven with the same traffic as the default build, so any difference in strobe decoding shows as a mismatch between the two on the same check.

// File: rtl/hdp_pkg.sv
package hdp_pkg;

    localparam int SLOTS = 4;

    localparam logic [3:0] A_STATUS = 4'h0;
    localparam logic [3:0] A_CTRL   = 4'h1;
    localparam logic [3:0] A_LAST   = 4'h7;

    typedef struct packed {
        logic req_hi;
        logic dual_req;
        logic big_end;
    } ctrl_t;

    // Slot addressed by the low two address bits in the current lane order.
    function automatic logic [1:0] slot_sel(input logic [1:0] low, input logic big_end);
        return big_end ? low : ~low;
    endfunction

    function automatic logic is_slot_addr(input logic [3:0] a);
        return a[3:2] == 2'b01;
    endfunction

endpackage

// File: rtl/hdp_sync.sv
module hdp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hdp_fifo.sv
module hdp_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_i && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = data_i;
            st_d.wp = (st_q.wp == PW'(DEPTH-1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH-1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/hdp_port.sv
module hdp_port
    import hdp_pkg::*;
#(
    parameter int DW           = 16,
    parameter int FIFO_DEPTH   = 2,
    parameter int SYNC_STAGES  = 2,
    parameter bit DUAL_STROBE  = 1'b1,
    parameter bit STB_ACT_HIGH = 1'b0
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                hsel_i,
    input  logic                hstb_a_i,
    input  logic                hstb_b_i,
    input  logic                hrw_i,
    input  logic [3:0]          haddr_i,
    input  logic [DW-1:0]       hdata_i,
    output logic [DW-1:0]       hdata_o,
    output logic                hdata_oe_o,
    output logic                hreq_o,
    output logic                hreq_rd_o,
    output logic                hreq_wr_o,
    output logic                h2c_valid_o,
    output logic [SLOTS*DW-1:0] h2c_data_o,
    input  logic                h2c_ready_i,
    input  logic                c2h_valid_i,
    input  logic [SLOTS*DW-1:0] c2h_data_i,
    output logic                c2h_ready_o
);
    localparam int   WW  = SLOTS * DW;
    localparam int   PIW = 4 + 4 + DW;
    localparam logic INV = STB_ACT_HIGH ? 1'b0 : 1'b1;

    typedef struct packed {
        ctrl_t         ctrl;
        logic [WW-1:0] asm_w;
        logic [3:0]    addr;
        logic [DW-1:0] wdat;
        logic          rd_act;
        logic          wr_act;
        logic [DW-1:0] rdata;
        logic          oe;
        logic          req;
        logic          req_rd;
        logic          req_wr;
    } port_st_t;

    port_st_t st_d, st_q;

    // Control pins normalised to active-high before the synchronizer.
    logic [PIW-1:0] pins_raw, pins_s;
    logic           s_sel, s_a, s_b, s_rw, s_rd, s_wr;
    logic [3:0]     s_addr;
    logic [DW-1:0]  s_data;

    assign pins_raw = {hsel_i ^ INV, hstb_a_i ^ INV, hstb_b_i ^ INV, hrw_i, haddr_i, hdata_i};

    hdp_sync #(.W(PIW), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign {s_sel, s_a, s_b, s_rw, s_addr, s_data} = pins_s;
    assign s_rd = DUAL_STROBE ? s_a : (s_a & s_rw);
    assign s_wr = DUAL_STROBE ? s_b : (s_a & ~s_rw);

    logic          h2c_push, h2c_full, h2c_empty;
    logic          c2h_pop, c2h_full, c2h_empty;
    logic [WW-1:0] merged, c2h_head;
    logic          rd_now, wr_now, rd_done, wr_done, rd_cond, wr_cond;
    logic [1:0]    wslot, rslot;

    always_comb begin
        st_d = st_q;
        rd_now = s_sel & s_rd;
        wr_now = s_sel & s_wr;
        st_d.rd_act = rd_now;
        st_d.wr_act = wr_now;
        if (rd_now || wr_now) begin
            st_d.addr = s_addr;
            st_d.wdat = s_data;
        end
        // Accesses complete on the trailing edge of the synchronized strobe.
        rd_done = st_q.rd_act & ~s_rd;
        wr_done = st_q.wr_act & ~s_wr;

        wslot  = slot_sel(st_q.addr[1:0], st_q.ctrl.big_end);
        merged = st_q.asm_w;
        merged[wslot*DW +: DW] = st_q.wdat;

        h2c_push = 1'b0;
        c2h_pop  = 1'b0;
        if (wr_done) begin
            if (st_q.addr == A_CTRL)     st_d.ctrl  = ctrl_t'(st_q.wdat[2:0]);
            if (is_slot_addr(st_q.addr)) st_d.asm_w = merged;
            if (st_q.addr == A_LAST)     h2c_push   = 1'b1;
        end
        if (rd_done && (st_q.addr == A_LAST)) c2h_pop = 1'b1;

        // Read data follows the live synchronized address.
        rslot = slot_sel(s_addr[1:0], st_q.ctrl.big_end);
        st_d.rdata = '0;
        if (s_addr == A_STATUS) begin
            st_d.rdata[0] = ~c2h_empty;
            st_d.rdata[1] = ~h2c_full;
        end else if (s_addr == A_CTRL) begin
            st_d.rdata[2:0] = st_q.ctrl;
        end else if (is_slot_addr(s_addr)) begin
            st_d.rdata = c2h_head[rslot*DW +: DW];
        end
        st_d.oe = rd_now;

        rd_cond = ~c2h_empty;
        wr_cond = ~h2c_full;
        st_d.req    = (~st_q.ctrl.dual_req & (rd_cond | wr_cond)) ~^ st_q.ctrl.req_hi;
        st_d.req_rd = (st_q.ctrl.dual_req & rd_cond) ~^ st_q.ctrl.req_hi;
        st_d.req_wr = (st_q.ctrl.dual_req & wr_cond) ~^ st_q.ctrl.req_hi;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q        <= '0;
            st_q.req    <= 1'b1;
            st_q.req_rd <= 1'b1;
            st_q.req_wr <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    hdp_fifo #(.W(WW), .DEPTH(FIFO_DEPTH)) u_h2c (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (h2c_push),
        .data_i  (merged),
        .pop_i   (h2c_ready_i),
        .head_o  (h2c_data_o),
        .empty_o (h2c_empty),
        .full_o  (h2c_full)
    );

    hdp_fifo #(.W(WW), .DEPTH(FIFO_DEPTH)) u_c2h (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .push_i  (c2h_valid_i),
        .data_i  (c2h_data_i),
        .pop_i   (c2h_pop),
        .head_o  (c2h_head),
        .empty_o (c2h_empty),
        .full_o  (c2h_full)
    );

    assign hdata_o     = st_q.rdata;
    assign hdata_oe_o  = st_q.oe;
    assign hreq_o      = st_q.req;
    assign hreq_rd_o   = st_q.req_rd;
    assign hreq_wr_o   = st_q.req_wr;
    assign h2c_valid_o = ~h2c_empty;
    assign c2h_ready_o = ~c2h_full;
endmodule

// File: rtl/hdp_port_chk.sv
module hdp_port_chk #(
    parameter int WW = 64
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic [2:0]    ctrl_i,
    input logic          c2h_empty_i,
    input logic          h2c_full_i,
    input logic          hreq_o,
    input logic          hreq_rd_o,
    input logic          hreq_wr_o,
    input logic          h2c_valid_o,
    input logic          h2c_ready_i,
    input logic [WW-1:0] h2c_data_o
);
    logic armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) armed_q <= 1'b0;
        else       armed_q <= 1'b1;
    end

    // R9: shared request follows both FIFO conditions in single-request mode
    a_r9_single_req: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        !$past(ctrl_i[1]) |-> (hreq_o == (($past(!c2h_empty_i) || $past(!h2c_full_i)) ~^ $past(ctrl_i[2]))
                               && hreq_rd_o == !$past(ctrl_i[2]) && hreq_wr_o == !$past(ctrl_i[2])));

    // R10: read request tracks core-to-host occupancy in dual-request mode
    a_r10_dual_rd: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        $past(ctrl_i[1]) |-> hreq_rd_o == ($past(!c2h_empty_i) ~^ $past(ctrl_i[2])));

    // R10: write request tracks host-to-core room in dual-request mode
    a_r10_dual_wr: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        $past(ctrl_i[1]) |-> hreq_wr_o == ($past(!h2c_full_i) ~^ $past(ctrl_i[2])));

    // R10: shared line idles in dual-request mode
    a_r10_shared_idle: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        $past(ctrl_i[1]) |-> hreq_o == !$past(ctrl_i[2]));

    // R13: offered word holds until taken
    a_r13_hold_word: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (h2c_valid_o && !h2c_ready_i) |=> (h2c_valid_o && $stable(h2c_data_o)));
endmodule

bind hdp_port hdp_port_chk #(.WW(hdp_pkg::SLOTS * DW)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ctrl_i      (st_q.ctrl),
    .c2h_empty_i (c2h_empty),
    .h2c_full_i  (h2c_full),
    .hreq_o      (hreq_o),
    .hreq_rd_o   (hreq_rd_o),
    .hreq_wr_o   (hreq_wr_o),
    .h2c_valid_o (h2c_valid_o),
    .h2c_ready_i (h2c_ready_i),
    .h2c_data_o  (h2c_data_o)
);

// File: tb/hdp_port_tb.sv
module hdp_port_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // default build: dual strobe, active low
    logic sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    // second build: single strobe, active high
    logic ss_sel = 1'b0, ss_ds = 1'b0;
    logic rw = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        h2c_ready = 1'b0, c2h_valid = 1'b0;
    logic [63:0] c2h_data = '0;

    logic [15:0] hd0, hd1;
    logic        oe0, oe1, rq0, rq1, rr0, rr1, rw0, rw1, hv0, hv1, cr0, cr1;
    logic [63:0] hdat0, hdat1;

    hdp_port u_dut (
        .clk_i(clk), .rst_i(rst), .hsel_i(sel_n), .hstb_a_i(rd_n), .hstb_b_i(wr_n),
        .hrw_i(rw), .haddr_i(addr), .hdata_i(wdata), .hdata_o(hd0), .hdata_oe_o(oe0),
        .hreq_o(rq0), .hreq_rd_o(rr0), .hreq_wr_o(rw0), .h2c_valid_o(hv0), .h2c_data_o(hdat0),
        .h2c_ready_i(h2c_ready), .c2h_valid_i(c2h_valid), .c2h_data_i(c2h_data), .c2h_ready_o(cr0));

    hdp_port #(.DUAL_STROBE(1'b0), .STB_ACT_HIGH(1'b1)) u_dut_ss (
        .clk_i(clk), .rst_i(rst), .hsel_i(ss_sel), .hstb_a_i(ss_ds), .hstb_b_i(1'b0),
        .hrw_i(rw), .haddr_i(addr), .hdata_i(wdata), .hdata_o(hd1), .hdata_oe_o(oe1),
        .hreq_o(rq1), .hreq_rd_o(rr1), .hreq_wr_o(rw1), .h2c_valid_o(hv1), .h2c_data_o(hdat1),
        .h2c_ready_i(h2c_ready), .c2h_valid_i(c2h_valid), .c2h_data_i(c2h_data), .c2h_ready_o(cr1));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk2(input string tag, input logic [63:0] a0, input logic [63:0] a1, input logic [63:0] exp);
        chk(a0 === exp, {tag, " dual-strobe"}, a0, exp);
        chk(a1 === exp, {tag, " single-strobe (R2)"}, a1, exp);
    endtask

    function automatic logic [15:0] exp_slot(input logic [63:0] w, input int a, input bit be);
        int s;
        s = be ? (a - 4) : (7 - a);
        return w[s*16 +: 16];
    endfunction

    task automatic host_acc(input bit is_rd, input logic [3:0] a, input logic [15:0] d,
                            output logic [15:0] r0, output logic [15:0] r1);
        @(negedge clk);
        addr = a; wdata = d; rw = is_rd; sel_n = 1'b0; ss_sel = 1'b1;
        @(negedge clk);
        if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        ss_ds = 1'b1;
        repeat (5) @(negedge clk);
        r0 = hd0; r1 = hd1;
        rd_n = 1'b1; wr_n = 1'b1; ss_ds = 1'b0;
        @(negedge clk);
        sel_n = 1'b1; ss_sel = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [15:0] d);
        logic [15:0] x0, x1;
        host_acc(1'b0, a, d, x0, x1);
    endtask

    task automatic host_rd(input logic [3:0] a, output logic [15:0] r0, output logic [15:0] r1);
        host_acc(1'b1, a, 16'h0, r0, r1);
    endtask

    task automatic put_word(input logic [63:0] w, input bit be);
        int start;
        start = int'($urandom % 3);
        for (int i = 0; i < 3; i++) begin
            host_wr(4'(4 + ((start + i) % 3)), exp_slot(w, 4 + ((start + i) % 3), be));
        end
        host_wr(4'h7, exp_slot(w, 7, be));
    endtask

    task automatic pull(output logic [63:0] w0, output logic [63:0] w1, output logic v0, output logic v1);
        @(negedge clk);
        w0 = hdat0; w1 = hdat1; v0 = hv0; v1 = hv1;
        h2c_ready = 1'b1;
        @(negedge clk);
        h2c_ready = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic push_c2h(input logic [63:0] w);
        @(negedge clk);
        c2h_valid = 1'b1; c2h_data = w;
        @(negedge clk);
        c2h_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_word(input logic [63:0] w, input bit be, input string tag);
        logic [15:0] r0, r1;
        for (int a = 4; a <= 7; a++) begin
            host_rd(4'(a), r0, r1);
            chk2(tag, 64'(r0), 64'(r1), 64'(exp_slot(w, a, be)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r0, r1, s0, s1;
        logic [63:0] w, wa, wb, wc, g0, g1;
        logic        v0, v1;
        int          n;
        bit          be;

        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk2("R1 h2c_valid after reset", 64'(hv0), 64'(hv1), 64'h0);
        chk2("R1 c2h_ready after reset", 64'(cr0), 64'(cr1), 64'h1);
        host_rd(4'h1, r0, r1);
        chk2("R1 control after reset", 64'(r0), 64'(r1), 64'h0);
        host_rd(4'h0, r0, r1);
        chk2("R8 status after reset", 64'(r0), 64'(r1), 64'h2);
        // R9 single mode, active low: room present -> shared line low
        chk2("R9 hreq single", 64'(rq0), 64'(rq1), 64'h0);
        chk2("R9 hreq_rd idle", 64'(rr0), 64'(rr1), 64'h1);
        chk2("R9 hreq_wr idle", 64'(rw0), 64'(rw1), 64'h1);

        // R3 little-endian assembly, random words
        for (int i = 0; i < 8; i++) begin
            w = {$urandom, $urandom};
            put_word(w, 1'b0);
            pull(g0, g1, v0, v1);
            chk2("R3 word valid", 64'(v0), 64'(v1), 64'h1);
            chk2("R3 little-endian word", g0, g1, w);
        end
        chk2("R13 valid low when drained", 64'(hv0), 64'(hv1), 64'h0);

        // R4 big-endian assembly
        host_wr(4'h1, 16'h0001);
        host_rd(4'h1, r0, r1);
        chk2("R8 control readback", 64'(r0), 64'(r1), 64'h1);
        for (int i = 0; i < 8; i++) begin
            w = {$urandom, $urandom};
            put_word(w, 1'b1);
            pull(g0, g1, v0, v1);
            chk2("R4 big-endian word", g0, g1, w);
        end

        // R7 overflow discard, R8 room bit, R13 hold
        wa = {$urandom, $urandom}; wb = {$urandom, $urandom}; wc = {$urandom, $urandom};
        put_word(wa, 1'b1);
        repeat (5) @(negedge clk);
        chk2("R13 word held while not ready", hdat0, hdat1, wa);
        put_word(wb, 1'b1);
        host_rd(4'h0, r0, r1);
        chk2("R8 status full", 64'(r0), 64'(r1), 64'h0);
        put_word(wc, 1'b1);
        pull(g0, g1, v0, v1);
        chk2("R7 first kept", g0, g1, wa);
        pull(g0, g1, v0, v1);
        chk2("R7 second kept", g0, g1, wb);
        chk2("R7 third dropped", 64'(hv0), 64'(hv1), 64'h0);

        // R5 host reads of core words, both lane orders
        for (int i = 0; i < 6; i++) begin
            be = i[0];
            host_wr(4'h1, {15'h0, be});
            w = {$urandom, $urandom};
            push_c2h(w);
            host_rd(4'h0, r0, r1);
            chk2("R8 status word waiting", 64'(r0), 64'(r1), 64'h3);
            host_rd(4'h4, r0, r1);
            chk2("R5 slot read no pop", 64'(r0), 64'(r1), 64'(exp_slot(w, 4, be)));
            read_word(w, be, "R5 slot read");
            host_rd(4'h0, r0, r1);
            chk2("R5 last read pops", 64'(r0), 64'(r1), 64'h2);
        end

        // R6 closing read on empty FIFO
        host_wr(4'h1, 16'h0000);
        host_rd(4'h7, r0, r1);
        host_rd(4'h7, s0, s1);
        chk2("R6 empty read repeatable", 64'(s0), 64'(s1), 64'(r0));
        host_rd(4'h0, r0, r1);
        chk2("R6 still empty", 64'(r0), 64'(r1), 64'h2);
        w = {$urandom, $urandom};
        push_c2h(w);
        read_word(w, 1'b0, "R6 next word intact");

        // R13 core-to-host full
        wa = {$urandom, $urandom}; wb = {$urandom, $urandom}; wc = {$urandom, $urandom};
        push_c2h(wa);
        push_c2h(wb);
        chk2("R13 c2h_ready low when full", 64'(cr0), 64'(cr1), 64'h0);
        push_c2h(wc);
        read_word(wa, 1'b0, "R13 first word");
        read_word(wb, 1'b0, "R13 second word");
        host_rd(4'h0, r0, r1);
        chk2("R13 third not taken", 64'(r0), 64'(r1), 64'h2);

        // R8 unmapped addresses
        host_wr(4'h2, 16'hFFFF);
        host_rd(4'h1, r0, r1);
        chk2("R8 unmapped write ignored", 64'(r0), 64'(r1), 64'h0);
        host_rd(4'h2, r0, r1);
        chk2("R8 unmapped read addr2", 64'(r0), 64'(r1), 64'h0);
        host_rd(4'h3, r0, r1);
        chk2("R8 unmapped read addr3", 64'(r0), 64'(r1), 64'h0);
        host_rd(4'h8, r0, r1);
        chk2("R8 unmapped read addr8", 64'(r0), 64'(r1), 64'h0);
        host_rd(4'hF, r0, r1);
        chk2("R8 unmapped read addr15", 64'(r0), 64'(r1), 64'h0);

        // R10 dual request, active low
        host_wr(4'h1, 16'h0002);
        chk2("R10 shared idle", 64'(rq0), 64'(rq1), 64'h1);
        chk2("R10 rd inactive when empty", 64'(rr0), 64'(rr1), 64'h1);
        chk2("R10 wr active with room", 64'(rw0), 64'(rw1), 64'h0);
        w = {$urandom, $urandom};
        push_c2h(w);
        chk2("R10 rd active with word", 64'(rr0), 64'(rr1), 64'h0);
        read_word(w, 1'b0, "R10 drain word");
        chk2("R10 rd inactive after drain", 64'(rr0), 64'(rr1), 64'h1);
        wa = {$urandom, $urandom}; wb = {$urandom, $urandom};
        put_word(wa, 1'b0);
        chk2("R10 wr active one entry", 64'(rw0), 64'(rw1), 64'h0);

        // R12 request latency on the closing write
        for (int a = 4; a <= 6; a++) host_wr(4'(a), exp_slot(wb, a, 1'b0));
        @(negedge clk);
        addr = 4'h7; wdata = exp_slot(wb, 7, 1'b0); rw = 1'b0; sel_n = 1'b0; ss_sel = 1'b1;
        @(negedge clk);
        wr_n = 1'b0; ss_ds = 1'b1;
        repeat (5) @(negedge clk);
        wr_n = 1'b1; ss_ds = 1'b0;
        n = 0;
        while (n < 12 && !(rw0 === 1'b1 && rw1 === 1'b1)) begin
            @(negedge clk);
            n++;
            if (n == 1) begin sel_n = 1'b1; ss_sel = 1'b0; end
        end
        chk(n <= 5, "R12 request within 5 cycles", 64'(n), 64'd5);
        repeat (4) @(negedge clk);
        chk2("R10 wr inactive when full", 64'(rw0), 64'(rw1), 64'h1);

        // R11 active-high requests
        host_wr(4'h1, 16'h0006);
        chk2("R11 wr inactive high-pol full", 64'(rw0), 64'(rw1), 64'h0);
        pull(g0, g1, v0, v1);
        chk2("R11 drained word", g0, g1, wa);
        repeat (2) @(negedge clk);
        chk2("R11 wr active high", 64'(rw0), 64'(rw1), 64'h1);
        chk2("R11 rd inactive high-pol", 64'(rr0), 64'(rr1), 64'h0);
        chk2("R11 shared idle high-pol", 64'(rq0), 64'(rq1), 64'h0);
        host_wr(4'h1, 16'h0004);
        chk2("R11 single active high", 64'(rq0), 64'(rq1), 64'h1);
        pull(g0, g1, v0, v1);
        chk2("R11 second drained", g0, g1, wb);
        host_wr(4'h1, 16'h0000);
        chk2("R9 single low again", 64'(rq0), 64'(rq1), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule